// File: doc/BRIEF.md
# Sync-Header Block and Message Aligner

This block sits on the receive side of a lane that carries 64B/66B-coded data. Each cycle it may accept one 66-bit word of raw received bits whose block boundary is unknown. It searches bit offsets for the position where the 2-bit sync header sits at the start of every 66-bit block. It declares block lock, and drops it again when headers go bad. While block lock holds, it delivers each aligned block as a 64-bit payload with its 2-bit header.

Once blocks are aligned, the block builds a second level of alignment. One bit of every header is collected into a 32-bit message. A fixed pilot field inside that message marks where each message starts. After the pilot has been seen at the same place in several messages in a row, the block reports message lock and outputs every complete message with a strobe.

Top module: `sync_hdr_aligner`

## Requirements
- R1: Each cycle with `inValid` high brings 66 bits, with bit 0 received first. The first such word after reset only primes the block. Each later word forms a 132-bit span with the previous word in the low half. The candidate block is the 66 bits of that span starting at the current offset (0..65). Words presented with `inValid` low are ignored.
- R2: A block's header is its two lowest bits and its payload is bits 65:2. The header values 2'b01 and 2'b10 are valid. The values 2'b00 and 2'b11 are header errors.
- R3: Before block lock, an invalid header moves the offset forward by one bit (65 wraps to 0) and clears the run of valid headers. After reset the search starts at offset 0.
- R4: `blockLock` rises after LOCK_CNT consecutive valid headers at one offset. The offset does not change while `blockLock` is high.
- R5: Windows of WIN_LEN blocks are counted from the moment lock is gained. If ERR_LIM invalid headers fall within one window, `blockLock` drops on the block that reaches the limit. The search then resumes from the same offset.
- R6: For every block accepted while `blockLock` is high, including the block that drops lock, `outValid` pulses one cycle later with that block's payload and header. Blocks accepted without lock produce no `outValid`.
- R7: The message bit of a block is header bit 0. Message bits are collected only from blocks accepted under block lock. The earliest bit of a message lands in bit 0 of `msgData`.
- R8: The pilot is PILOT_W bits at `msgData[PILOT_LSB +: PILOT_W]`, with the default value 12'hCA3 in bits 31:20. The first 32-bit window holding the pilot fixes a message boundary. `msgLock` rises when MSG_LOCK_CNT consecutive messages on that boundary carry the pilot. A message without the pilot clears `msgLock` and restarts the pilot search.
- R9: `msgValid` pulses only on a boundary where `msgLock` is high after that message, and `msgData` then holds a message carrying the pilot. `msgLock` is never high without `blockLock`. Losing block lock clears all message state and sends no message for that block.
- R10: A synchronous reset clears both locks and all output strobes and returns the offset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Raw word present this cycle |
| inData | input | 66 | Raw received bits, bit 0 first |
| outValid | output | 1 | Aligned block strobe |
| outPayload | output | 64 | Aligned block payload |
| outHdr | output | 2 | Aligned block sync header |
| blockLock | output | 1 | Block boundary found |
| msgLock | output | 1 | Message boundary found |
| msgValid | output | 1 | Complete message strobe |
| msgData | output | 32 | Assembled header-bit message |

## Verification
The bench builds the block with LOCK_CNT=16, WIN_LEN=32, ERR_LIM=6 and MSG_LOCK_CNT=3. The block width, the message width and the pilot keep their defaults. The shorter thresholds let a few thousand cycles cover several cases: gaining lock from several bit skews, keeping lock when errors stay under the limit, losing lock when a burst reaches it, regaining lock afterwards, and losing and regaining message lock when pilots are corrupted. Gaps in `inValid` carrying junk data are mixed in to show that skipped cycles change nothing.

// File: rtl/sha_pkg.sv
package sha_pkg;
  localparam int BLK_W = 66;
  localparam int HDR_W = 2;
  localparam int PAY_W = BLK_W - HDR_W;
  localparam int OFF_W = $clog2(BLK_W);

  typedef enum logic {MS_SEARCH, MS_TRACK} msgState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [OFF_W-1:0] offset;
    logic             emitBlk;
    logic             shiftSync;
    logic             emitMsg;
  } ctrl_t;

  // observations from datapath to control
  typedef struct packed {
    logic blkAvail;
    logic hdrOk;
    logic pilotHit;
  } stat_t;
endpackage

// File: rtl/sha_datapath.sv
module sha_datapath
  import sha_pkg::*;
#(
  parameter int MSG_W = 32,
  parameter int PILOT_W = 12,
  parameter int PILOT_LSB = 20,
  parameter logic [PILOT_W-1:0] PILOT = 12'hCA3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [BLK_W-1:0]  inData,
  input  ctrl_t             ctrl,
  output stat_t             stat,
  output logic              outValid,
  output logic [PAY_W-1:0]  outPayload,
  output logic [HDR_W-1:0]  outHdr,
  output logic              msgValid,
  output logic [MSG_W-1:0]  msgData
);
  localparam int SPAN_W = 2 * BLK_W;

  logic [BLK_W-1:0]  prevWord;
  logic              primed;
  logic [SPAN_W-1:0] span;
  logic [SPAN_W-1:0] shifted;
  logic [BLK_W-1:0]  blk;
  logic [MSG_W-2:0]  syncHist;
  logic [MSG_W-1:0]  syncNext;

  always_comb begin
    span     = {inData, prevWord};
    shifted  = span >> ctrl.offset;
    blk      = shifted[BLK_W-1:0];
    syncNext = {blk[0], syncHist};
  end

  assign stat.blkAvail = inValid & primed;
  assign stat.hdrOk    = blk[0] ^ blk[1];
  assign stat.pilotHit = (syncNext[PILOT_LSB +: PILOT_W] == PILOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      primed     <= 1'b0;
      outValid   <= 1'b0;
      outPayload <= '0;
      outHdr     <= '0;
      msgValid   <= 1'b0;
      msgData    <= '0;
      syncHist   <= '0;
    end else begin
      if (inValid) begin
        prevWord <= inData;
        primed   <= 1'b1;
      end
      outValid <= ctrl.emitBlk;
      if (ctrl.emitBlk) begin
        outPayload <= blk[BLK_W-1:HDR_W];
        outHdr     <= blk[HDR_W-1:0];
      end
      if (ctrl.shiftSync) syncHist <= syncNext[MSG_W-1:1];
      msgValid <= ctrl.emitMsg;
      if (ctrl.emitMsg) msgData <= syncNext;
    end
  end

  // R9: an emitted message always carries the pilot
  a_r9_msg_has_pilot: assert property (@(posedge clk) disable iff (rst)
    msgValid |-> (msgData[PILOT_LSB +: PILOT_W] == PILOT));

  // R1: control only emits a block when a primed word arrived
  a_r1_emit_needs_word: assert property (@(posedge clk) disable iff (rst)
    ctrl.emitBlk |-> (inValid && primed));
endmodule

// File: rtl/sha_control.sv
module sha_control
  import sha_pkg::*;
#(
  parameter int LOCK_CNT = 64,
  parameter int WIN_LEN = 64,
  parameter int ERR_LIM = 16,
  parameter int MSG_W = 32,
  parameter int MSG_LOCK_CNT = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  stat_t stat,
  output ctrl_t ctrl,
  output logic  blockLock,
  output logic  msgLock
);
  localparam int GW = $clog2(LOCK_CNT + 1);
  localparam int WW = $clog2(WIN_LEN + 1);
  localparam int EW = $clog2(ERR_LIM + 1);
  localparam int FW = $clog2(MSG_W + 1);
  localparam int PW = $clog2(MSG_W);
  localparam int NW = $clog2(MSG_LOCK_CNT + 1);
  localparam logic [GW-1:0]    GOOD_LAST = GW'(LOCK_CNT - 1);
  localparam logic [WW-1:0]    WIN_LAST  = WW'(WIN_LEN - 1);
  localparam logic [EW-1:0]    ERR_LAST  = EW'(ERR_LIM - 1);
  localparam logic [FW-1:0]    FILL_MAX  = FW'(MSG_W);
  localparam logic [FW-1:0]    FILL_FULL = FW'(MSG_W - 1);
  localparam logic [PW-1:0]    PH_LAST   = PW'(MSG_W - 1);
  localparam logic [NW-1:0]    N_MAX     = NW'(MSG_LOCK_CNT);
  localparam logic [NW-1:0]    N_LAST    = NW'(MSG_LOCK_CNT - 1);
  localparam logic [OFF_W-1:0] OFF_LAST  = OFF_W'(BLK_W - 1);

  logic [OFF_W-1:0] offset;
  logic [GW-1:0]    goodCnt;
  logic [WW-1:0]    winCnt;
  logic [EW-1:0]    errCnt;
  logic [FW-1:0]    fill;
  logic [PW-1:0]    phase;
  logic [NW-1:0]    nMsg;
  msgState_e        mState;
  logic             dropLock;
  logic             boundary;

  function automatic logic [OFF_W-1:0] nextOff(input logic [OFF_W-1:0] o);
    return (o == OFF_LAST) ? '0 : o + 1'b1;
  endfunction

  always_comb begin
    dropLock       = blockLock & stat.blkAvail & ~stat.hdrOk & (errCnt == ERR_LAST);
    boundary       = (mState == MS_TRACK) & (phase == PH_LAST);
    ctrl.offset    = offset;
    ctrl.emitBlk   = stat.blkAvail & blockLock;
    ctrl.shiftSync = stat.blkAvail & blockLock;
    ctrl.emitMsg   = ctrl.shiftSync & ~dropLock & boundary & stat.pilotHit & (nMsg >= N_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      offset    <= '0;
      blockLock <= 1'b0;
      goodCnt   <= '0;
      winCnt    <= '0;
      errCnt    <= '0;
      mState    <= MS_SEARCH;
      fill      <= '0;
      phase     <= '0;
      nMsg      <= '0;
      msgLock   <= 1'b0;
    end else if (stat.blkAvail) begin
      if (!blockLock) begin
        if (stat.hdrOk) begin
          if (goodCnt == GOOD_LAST) begin
            blockLock <= 1'b1;
            goodCnt   <= '0;
            winCnt    <= '0;
            errCnt    <= '0;
          end else begin
            goodCnt <= goodCnt + 1'b1;
          end
        end else begin
          offset  <= nextOff(offset);
          goodCnt <= '0;
        end
      end else if (dropLock) begin
        blockLock <= 1'b0;
        goodCnt   <= '0;
        winCnt    <= '0;
        errCnt    <= '0;
        mState    <= MS_SEARCH;
        fill      <= '0;
        phase     <= '0;
        nMsg      <= '0;
        msgLock   <= 1'b0;
      end else begin
        if (winCnt == WIN_LAST) begin
          winCnt <= '0;
          errCnt <= '0;
        end else begin
          winCnt <= winCnt + 1'b1;
          if (!stat.hdrOk) errCnt <= errCnt + 1'b1;
        end
        if (fill != FILL_MAX) fill <= fill + 1'b1;
        if (mState == MS_SEARCH) begin
          if ((fill >= FILL_FULL) && stat.pilotHit) begin
            mState <= MS_TRACK;
            phase  <= '0;
            nMsg   <= NW'(1);
          end
        end else if (phase == PH_LAST) begin
          phase <= '0;
          if (stat.pilotHit) begin
            if (nMsg != N_MAX) nMsg <= nMsg + 1'b1;
            if (nMsg >= N_LAST) msgLock <= 1'b1;
          end else begin
            mState  <= MS_SEARCH;
            nMsg    <= '0;
            msgLock <= 1'b0;
          end
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end

  // R3: an invalid header during search slips exactly one bit
  a_r3_slip_one_bit: assert property (@(posedge clk) disable iff (rst)
    (!blockLock && stat.blkAvail && !stat.hdrOk) |=> (offset == nextOff($past(offset))));

  // R4: offset frozen under lock
  a_r4_offset_held: assert property (@(posedge clk) disable iff (rst)
    blockLock |=> $stable(offset));

  // R4: lock only rises on an accepted valid header
  a_r4_lock_on_good: assert property (@(posedge clk) disable iff (rst)
    $rose(blockLock) |-> $past(stat.blkAvail && stat.hdrOk));

  // R9: message lock implies block lock
  a_r9_msglock_needs_blk: assert property (@(posedge clk) disable iff (rst)
    msgLock |-> blockLock);

  // R8: message lock rises only on a pilot
  a_r8_msglock_on_pilot: assert property (@(posedge clk) disable iff (rst)
    $rose(msgLock) |-> $past(stat.pilotHit));
endmodule

// File: rtl/sync_hdr_aligner.sv
module sync_hdr_aligner
  import sha_pkg::*;
#(
  parameter int LOCK_CNT = 64,
  parameter int WIN_LEN = 64,
  parameter int ERR_LIM = 16,
  parameter int MSG_W = 32,
  parameter int PILOT_W = 12,
  parameter int PILOT_LSB = 20,
  parameter logic [PILOT_W-1:0] PILOT = 12'hCA3,
  parameter int MSG_LOCK_CNT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [BLK_W-1:0]  inData,
  output logic              outValid,
  output logic [PAY_W-1:0]  outPayload,
  output logic [HDR_W-1:0]  outHdr,
  output logic              blockLock,
  output logic              msgLock,
  output logic              msgValid,
  output logic [MSG_W-1:0]  msgData
);
  ctrl_t ctrl;
  stat_t stat;

  sha_datapath #(
    .MSG_W(MSG_W), .PILOT_W(PILOT_W), .PILOT_LSB(PILOT_LSB), .PILOT(PILOT)
  ) u_dp (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .ctrl(ctrl), .stat(stat),
    .outValid(outValid), .outPayload(outPayload), .outHdr(outHdr),
    .msgValid(msgValid), .msgData(msgData)
  );

  sha_control #(
    .LOCK_CNT(LOCK_CNT), .WIN_LEN(WIN_LEN), .ERR_LIM(ERR_LIM),
    .MSG_W(MSG_W), .MSG_LOCK_CNT(MSG_LOCK_CNT)
  ) u_ctl (
    .clk(clk), .rst(rst), .stat(stat), .ctrl(ctrl),
    .blockLock(blockLock), .msgLock(msgLock)
  );
endmodule

// File: tb/sync_hdr_aligner_tb.sv
module sync_hdr_aligner_tb;
  localparam int LOCK_N  = 16;
  localparam int WIN_N   = 32;
  localparam int ERR_N   = 6;
  localparam int MLOCK_N = 3;
  localparam logic [11:0] PIL = 12'hCA3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [65:0] inData = '0;
  logic        outValid, blockLock, msgLock, msgValid;
  logic [63:0] outPayload;
  logic [1:0]  outHdr;
  logic [31:0] msgData;

  sync_hdr_aligner #(
    .LOCK_CNT(LOCK_N), .WIN_LEN(WIN_N), .ERR_LIM(ERR_N), .MSG_LOCK_CNT(MLOCK_N)
  ) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outPayload(outPayload), .outHdr(outHdr),
    .blockLock(blockLock), .msgLock(msgLock),
    .msgValid(msgValid), .msgData(msgData)
  );

  always #2 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      mismatched++;
      $display("FAIL R10 watchdog expired: actual cycles=%0d expected below 50000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // ---------------- stimulus generator ----------------
  bit          txq[$];
  int          corruptEvery = 0;
  int          blkCnt = 0;
  bit          pilotBad = 0;
  logic [31:0] curMsg;
  int          msgPos = 0;

  task automatic pushBlock();
    logic [1:0]  hdr;
    logic [63:0] pay;
    bit          s;
    if (msgPos == 0) curMsg = {(pilotBad ? ~PIL : PIL), 20'($urandom)};
    s = curMsg[msgPos];
    msgPos = (msgPos + 1) % 32;
    hdr = {~s, s};
    blkCnt++;
    if (corruptEvery > 0 && (blkCnt % corruptEvery) == 0) hdr = blkCnt[0] ? 2'b11 : 2'b00;
    pay = {$urandom, $urandom};
    txq.push_back(hdr[0]);
    txq.push_back(hdr[1]);
    for (int i = 0; i < 64; i++) txq.push_back(pay[i]);
  endtask

  task automatic nextWord(output logic [65:0] w);
    while (txq.size() < 66) pushBlock();
    for (int i = 0; i < 66; i++) w[i] = txq.pop_front();
  endtask

  task automatic restartTx(input int skew);
    txq.delete();
    msgPos = 0;
    for (int i = 0; i < skew; i++) txq.push_back(bit'($urandom));
  endtask

  // ---------------- reference model ----------------
  int          mOff, mGood, mWin, mErr, mFill, mPhase, mN;
  bit          mPrimed, mBL, mTrack;
  logic [65:0] mPrev;
  logic [31:0] mBits;
  logic        eOV, eBL, eML, eMV;
  logic [63:0] ePay;
  logic [1:0]  eHdr;
  logic [31:0] eMsg;
  bit          armed = 0;

  task automatic modelStep(input bit r, input bit v, input logic [65:0] d);
    logic [131:0] span;
    logic [65:0]  blk;
    bit ok, drop, full, hit;
    if (r) begin
      mOff = 0; mGood = 0; mWin = 0; mErr = 0; mFill = 0; mPhase = 0; mN = 0;
      mPrimed = 0; mBL = 0; mTrack = 0; mBits = '0;
      eOV = 0; eBL = 0; eML = 0; eMV = 0; ePay = '0; eHdr = '0; eMsg = '0;
      return;
    end
    eOV = 0; eMV = 0;
    if (!v) return;
    if (mPrimed) begin
      span = {d, mPrev};
      blk  = 66'(span >> mOff);
      ok   = (blk[1] != blk[0]);
      if (!mBL) begin
        if (ok) begin
          mGood++;
          if (mGood == LOCK_N) begin mBL = 1; mGood = 0; mWin = 0; mErr = 0; end
        end else begin
          mOff = (mOff + 1) % 66;
          mGood = 0;
        end
      end else begin
        eOV = 1; ePay = blk[65:2]; eHdr = blk[1:0];
        mBits = {blk[0], mBits[31:1]};
        drop = !ok && (mErr == ERR_N - 1);
        if (drop) begin
          mBL = 0; mGood = 0; mTrack = 0; mFill = 0; mPhase = 0; mN = 0; eML = 0;
        end else begin
          if (mWin == WIN_N - 1) begin mWin = 0; mErr = 0; end
          else begin mWin++; if (!ok) mErr++; end
          full = (mFill >= 31);
          if (mFill < 32) mFill++;
          hit = (mBits[31:20] == PIL);
          if (!mTrack) begin
            if (full && hit) begin mTrack = 1; mPhase = 0; mN = 1; end
          end else if (mPhase == 31) begin
            mPhase = 0;
            if (hit) begin
              if (mN < MLOCK_N) mN++;
              if (mN >= MLOCK_N) begin eML = 1; eMV = 1; eMsg = mBits; end
            end else begin
              mTrack = 0; mN = 0; eML = 0;
            end
          end else begin
            mPhase++;
          end
        end
      end
    end
    eBL = mBL;
    mPrev = d;
    mPrimed = 1;
  endtask

  task automatic compareAll();
    chk("R6 outValid", 64'(outValid), 64'(eOV));
    if (eOV) begin
      chk("R6 outPayload", outPayload, ePay);
      chk("R2 outHdr", 64'(outHdr), 64'(eHdr));
    end
    chk("R4 blockLock", 64'(blockLock), 64'(eBL));
    chk("R8 msgLock", 64'(msgLock), 64'(eML));
    chk("R9 msgValid", 64'(msgValid), 64'(eMV));
    if (eMV) chk("R7 msgData", 64'(msgData), 64'(eMsg));
  endtask

  bit gaps = 0;

  task automatic cycle(input bit r);
    logic [65:0] w;
    bit v;
    @(negedge clk);
    if (armed) compareAll();
    v = r ? 1'b0 : (gaps ? (($urandom % 10) >= 3) : 1'b1);
    if (v) nextWord(w);
    else w = {$urandom, $urandom, 2'($urandom)};
    rst = r; inValid = v; inData = w;
    modelStep(r, v, w);
    armed = 1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0);
  endtask

  initial begin
    restartTx(17);
    for (int i = 0; i < 4; i++) cycle(1'b1);
    cycle(1'b0);
    // R10: reset state visible after reset
    chk("R10 blockLock after reset", 64'(blockLock), 64'd0);
    chk("R10 msgLock after reset", 64'(msgLock), 64'd0);
    chk("R10 outValid after reset", 64'(outValid), 64'd0);

    // R3 R4 R8: clean stream with skew 17
    run(700);
    chk("R4 lock gained", 64'(blockLock), 64'd1);
    chk("R8 msg lock gained", 64'(msgLock), 64'd1);

    // R5: sparse errors, under the limit per window
    corruptEvery = 9;
    run(300);
    chk("R5 lock kept under limit", 64'(blockLock), 64'd1);

    // R5: dense errors drop lock
    corruptEvery = 3;
    run(80);
    chk("R5 lock lost at limit", 64'(blockLock), 64'd0);
    chk("R9 msg lock cleared with block lock", 64'(msgLock), 64'd0);

    // R3: relock on the same stream
    corruptEvery = 0;
    run(600);
    chk("R3 relock", 64'(blockLock), 64'd1);

    // R8: bad pilots drop message lock, good ones restore it
    pilotBad = 1;
    run(200);
    chk("R8 msg lock lost on bad pilot", 64'(msgLock), 64'd0);
    chk("R8 block lock kept", 64'(blockLock), 64'd1);
    pilotBad = 0;
    run(400);
    chk("R8 msg lock regained", 64'(msgLock), 64'd1);

    // R10: mid-stream reset, then R1 with gaps and new skew 40
    cycle(1'b1);
    cycle(1'b0);
    chk("R10 blockLock after mid reset", 64'(blockLock), 64'd0);
    restartTx(40);
    gaps = 1;
    run(1200);
    chk("R1 lock with gaps", 64'(blockLock), 64'd1);
    chk("R8 msg lock with gaps", 64'(msgLock), 64'd1);
    gaps = 0;

    // wrap-around skew 65
    cycle(1'b1);
    restartTx(65);
    run(800);
    chk("R3 lock at skew 65", 64'(blockLock), 64'd1);

    @(negedge clk);
    compareAll();
    summary();
    $finish;
  end
endmodule